// File: doc/BRIEF.md
# Wake-Capable Serial Character Receiver

This block receives asynchronous serial characters on a single line and raises a wake signal when a received character falls inside a programmed range. It is meant to stay powered while the rest of the chip sleeps. A two-bit divisor slows the system clock down to a sampling tick at sixteen times the bit rate. On that tick the line is captured into a three-deep shift register. The receiver uses either the newest sample or a two-of-three majority of the last three samples.

A frame state machine recovers the character. It has five states: IDLE, START, DATA, PAR and STOP. IDLE moves to START on a low line level. START returns to IDLE at its half-bit sample if the line is high again, which marks a glitch, and otherwise moves to DATA. DATA shifts in eight bits LSB first, then moves to PAR when a parity mode is selected or to STOP when none is. PAR moves to STOP after one bit. STOP moves to IDLE at its mid-bit sample, and that sample completes the frame. Any state drops to IDLE when the receiver is disabled or reset.

A completed frame that passes its parity and stop checks is compared against a lower and an upper bound. A character inside the bounds sets a sticky wake flag. Software reaches six word registers through a simple read/write port. It can read the character, the flags and the configuration. A read of the holding register clears the flags. A write-protect bit, unlocked with a key, freezes the configuration.

Top module: `wake_uart_rx`

## Requirements
- R1: The sampling tick occurs once every DIV+1 clock cycles, where DIV sits in bits 1:0 of the divisor register (word 3). One bit lasts 16 ticks, and frames sent at that bit length are received for every DIV from 0 to 3.
- R2: A low line level starts a frame only if the line is still low at the eighth tick after the low level is first seen. A shorter low pulse produces no character and leaves the ready flag at 0.
- R3: When bit 4 of the mode register (word 1) is 1, the receiver uses the two-of-three majority of the last three tick samples. A single-tick low pulse inside a high bit then leaves that bit at 1. When bit 4 is 0, the receiver uses the latest sample.
- R4: Characters are 8 bits, sent LSB first, and appear in bits 7:0 of the holding register (word 2). Bit 10 of the same register is a ready flag that is set when a frame completes.
- R5: Parity is selected by bits 11:9 of the mode register. The values are 0 for even, 1 for odd, 2 for a parity bit that must be 0, 3 for a parity bit that must be 1, and 4 for no parity bit (values 5 to 7 also mean no parity bit). With no parity, the bit after the data bits is the stop bit.
- R6: A parity mismatch or a low stop bit sets the sticky error flag in holding bit 9. The failed character is not compared, so it cannot set the wake flag.
- R7: A good character C sets the sticky wake flag (holding bit 8, also on the wake port) when LO <= C <= HI. LO is bits 7:0 and HI is bits 23:16 of the compare register (word 4). LO equal to HI means an exact match, and LO greater than HI never matches.
- R8: A read of the holding register clears the wake, error and ready flags. A flag set by a frame that completes in the same cycle as that read stays set.
- R9: Writes to the control register (word 0) act as commands. Bit 4 enables the receiver and bit 5 disables it; if both are written in the same cycle, the receiver ends up disabled. Bit 2 aborts any frame in progress and clears all three flags. The enable state reads back in bit 4, its reset value is 0, and a disabled receiver ignores the line.
- R10: Bit 0 of the protect register (word 5) is the protect enable. A write to that register takes effect only if its bits 31:8 equal 0x52584C, and reads return 0 in bits 31:8. While protect is enabled, writes to the mode, divisor and compare registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Serial receive line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| wake | output | 1 | Sticky wake flag |

## Verification
Two functions of this block can act in the same clock cycle: the completion of a matching frame, which sets the wake flag, and a software read of the holding register, which clears it. The bench first sends a reference frame and counts the clock edges from the falling start bit to the rise of wake. It then sends an identical frame and issues the holding-register read on exactly that edge. The set must win: wake has to be high after that edge, and only a second read may clear it. A reset command issued in the middle of a frame is judged the same way, by checking that the wake flag and the ready flag are both clear once the rest of the frame has been sent.

// File: rtl/wurx_pkg.sv
package wurx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_HOLD = 3'd2;
    localparam logic [2:0] A_DIV  = 3'd3;
    localparam logic [2:0] A_CMP  = 3'd4;
    localparam logic [2:0] A_PROT = 3'd5;

    localparam int CMD_RST_BIT = 2;
    localparam int CMD_EN_BIT  = 4;
    localparam int CMD_DIS_BIT = 5;
    localparam int FILT_BIT    = 4;
    localparam int PAR_LSB     = 9;
    localparam int HI_LSB      = 16;

    localparam logic [23:0] PROT_KEY = 24'h52584C;

endpackage

// File: rtl/wurx_baud.sv
module wurx_baud #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/wurx_filter.sv
module wurx_filter #(
    parameter int VOTES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    input  logic filt_en,
    output logic line
);
    localparam int MAJ = VOTES / 2;

    logic [VOTES-1:0] smp;
    logic             maj;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    smp <= '1;
        else if (tick) smp <= {smp[VOTES-2:0], rx};
    end

    assign maj  = ($countones(smp) > MAJ);
    assign line = filt_en ? maj : smp[0];
endmodule

// File: rtl/wurx_fsm.sv
module wurx_fsm
    import wurx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              enable,
    input  logic              tick,
    input  logic              line,
    input  logic [2:0]        par_mode,
    output logic              done,
    output logic              bad,
    output logic [DATA_W-1:0] data
);
    localparam int CW   = $clog2(OS);
    localparam int BW   = $clog2(DATA_W);
    localparam int HALF = OS / 2;

    rx_state_e         state, nxt;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              pbit, has_par, sample, perr;

    assign has_par = (par_mode <= 3'd3);
    assign sample  = tick && ((state == ST_START) ? (cnt == CW'(HALF - 1))
                                                  : (cnt == CW'(OS - 1)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= ST_IDLE;
        else if (abort) state <= ST_IDLE;
        else            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (tick && !line) nxt = ST_START;
            ST_START: if (sample) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:  if (sample && bitn == BW'(DATA_W - 1))
                          nxt = has_par ? ST_PAR : ST_STOP;
            ST_PAR:   if (sample) nxt = ST_STOP;
            ST_STOP:  if (sample) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (!enable) nxt = ST_IDLE;
    end

    // sample counter and shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else begin
            if (abort)     cnt <= '0;
            else if (tick) cnt <= (state == ST_IDLE || sample) ? '0 : cnt + 1'b1;
            if (state == ST_START) bitn <= '0;
            else if (state == ST_DATA && sample) begin
                bitn  <= bitn + 1'b1;
                shreg <= {line, shreg[DATA_W-1:1]};
            end
            if (state == ST_PAR && sample) pbit <= line;
        end
    end

    // outputs
    always_comb begin
        unique case (par_mode)
            3'd0:    perr = ^{shreg, pbit};
            3'd1:    perr = ~^{shreg, pbit};
            3'd2:    perr = pbit;
            3'd3:    perr = !pbit;
            default: perr = 1'b0;
        endcase
        done = (state == ST_STOP) && sample;
        bad  = !line || perr;
        data = shreg;
    end
endmodule

// File: rtl/wake_uart_rx.sv
module wake_uart_rx
    import wurx_pkg::*;
#(
    parameter int DIV_W  = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              wake
);
    localparam int CH_W = 8;

    logic             rx_en, filt_en, prot_en;
    logic [2:0]       par_mode;
    logic [DIV_W-1:0] div_q;
    logic [CH_W-1:0]  val_lo, val_hi, hold;
    logic             f_wake, f_err, f_rdy;
    logic             tick, line, done_raw, done, bad, in_range;
    logic [CH_W-1:0]  ch;
    logic             wr_ctrl, cmd_rst, cmd_en, cmd_dis, rd_hold, cfg_ok;

    assign wr_ctrl = reg_wr && reg_addr == ADDR_W'(A_CTRL);
    assign cmd_rst = wr_ctrl && reg_wdata[CMD_RST_BIT];
    assign cmd_en  = wr_ctrl && reg_wdata[CMD_EN_BIT];
    assign cmd_dis = wr_ctrl && reg_wdata[CMD_DIS_BIT];
    assign rd_hold = reg_rd && reg_addr == ADDR_W'(A_HOLD);
    assign cfg_ok  = reg_wr && !prot_en;

    wurx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    wurx_filter #(.VOTES(3)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx),
        .filt_en(filt_en), .line(line)
    );

    wurx_fsm #(.DATA_W(CH_W), .OS(16)) u_fsm (
        .clk(clk), .rst_n(rst_n), .abort(cmd_rst), .enable(rx_en),
        .tick(tick), .line(line), .par_mode(par_mode),
        .done(done_raw), .bad(bad), .data(ch)
    );

    assign done     = done_raw && !cmd_rst;
    assign in_range = (ch >= val_lo) && (ch <= val_hi);
    assign wake     = f_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en    <= 1'b0;
            filt_en  <= 1'b0;
            par_mode <= 3'd0;
            div_q    <= '0;
            val_lo   <= '0;
            val_hi   <= '0;
            prot_en  <= 1'b0;
        end else begin
            if (cmd_dis)     rx_en <= 1'b0;
            else if (cmd_en) rx_en <= 1'b1;
            if (cfg_ok && reg_addr == ADDR_W'(A_MODE)) begin
                filt_en  <= reg_wdata[FILT_BIT];
                par_mode <= reg_wdata[PAR_LSB +: 3];
            end
            if (cfg_ok && reg_addr == ADDR_W'(A_DIV)) div_q <= reg_wdata[DIV_W-1:0];
            if (cfg_ok && reg_addr == ADDR_W'(A_CMP)) begin
                val_lo <= reg_wdata[CH_W-1:0];
                val_hi <= reg_wdata[HI_LSB +: CH_W];
            end
            if (reg_wr && reg_addr == ADDR_W'(A_PROT) && reg_wdata[31:8] == PROT_KEY)
                prot_en <= reg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold   <= '0;
            f_wake <= 1'b0;
            f_err  <= 1'b0;
            f_rdy  <= 1'b0;
        end else if (cmd_rst) begin
            f_wake <= 1'b0;
            f_err  <= 1'b0;
            f_rdy  <= 1'b0;
        end else begin
            if (rd_hold) begin
                f_wake <= 1'b0;
                f_err  <= 1'b0;
                f_rdy  <= 1'b0;
            end
            if (done) begin
                hold  <= ch;
                f_rdy <= 1'b1;
                if (bad)           f_err  <= 1'b1;
                else if (in_range) f_wake <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_CTRL): reg_rdata[CMD_EN_BIT] = rx_en;
            ADDR_W'(A_MODE): begin
                reg_rdata[FILT_BIT]       = filt_en;
                reg_rdata[PAR_LSB +: 3]   = par_mode;
            end
            ADDR_W'(A_HOLD): reg_rdata[10:0] = {f_rdy, f_err, f_wake, hold};
            ADDR_W'(A_DIV):  reg_rdata[DIV_W-1:0] = div_q;
            ADDR_W'(A_CMP):  begin
                reg_rdata[CH_W-1:0]       = val_lo;
                reg_rdata[HI_LSB +: CH_W] = val_hi;
            end
            ADDR_W'(A_PROT): reg_rdata[0] = prot_en;
            default:         reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wurx_chk.sv
module wurx_chk
    import wurx_pkg::*;
#(
    parameter int DIV_W  = 2,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [23:0]       key_rd,
    input logic              cmd_rst,
    input logic              cmd_dis,
    input logic              rx_en,
    input logic              prot_en,
    input logic              wake,
    input logic              f_err,
    input logic [DIV_W+19:0] cfg
);
    logic cfg_wr;
    assign cfg_wr = reg_wr && (reg_addr == ADDR_W'(A_MODE) ||
                               reg_addr == ADDR_W'(A_DIV)  ||
                               reg_addr == ADDR_W'(A_CMP));

    p_dis_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dis |=> !rx_en);

    p_rst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (!wake && !f_err));

    p_wake_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !(reg_rd && reg_addr == ADDR_W'(A_HOLD)) && !cmd_rst) |=> wake);

    p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && cfg_wr) |=> $stable(cfg));

    p_key_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(A_PROT)) |-> (key_rd == 24'd0));

    p_wake_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(rx_en));
endmodule

bind wake_uart_rx wurx_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .key_rd(reg_rdata[31:8]), .cmd_rst(cmd_rst),
    .cmd_dis(cmd_dis), .rx_en(rx_en), .prot_en(prot_en), .wake(wake),
    .f_err(f_err), .cfg({filt_en, par_mode, div_q, val_hi, val_lo})
);

// File: tb/sim_wake_uart_rx.sv
module sim_wake_uart_rx;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] KEY = 24'h52584C;

    typedef struct packed {
        logic [1:0] div;
        logic       filt;
        logic [2:0] par;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] ch;
        logic       badp;
        logic       bads;
        logic       ewake;
        logic       eerr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 3'd0, 8'h41, 8'h5A, 8'h4D, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd1, 1'b1, 3'd1, 8'h30, 8'h39, 8'h3A, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd2, 1'b0, 3'd2, 8'h55, 8'h55, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd3, 1'b1, 3'd3, 8'h00, 8'hFF, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'd0, 1'b0, 3'd4, 8'h10, 8'h20, 8'h20, 1'b1, 1'b0, 1'b1, 1'b0},
        '{2'd1, 1'b0, 3'd0, 8'h10, 8'h20, 8'h10, 1'b0, 1'b1, 1'b0, 1'b1},
        '{2'd0, 1'b1, 3'd1, 8'h80, 8'h7F, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 3'd0, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        wake;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    wake_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx(rx), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake(wake)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic drive_bit(input logic v, input int n, input bit glitch);
        for (int i = 0; i < n; i++) begin
            rx = (glitch && v && (i % 3 == 2)) ? 1'b0 : v;
            @(negedge clk);
        end
    endtask

    task automatic send(input logic [7:0] ch, input logic [2:0] par, input logic badp,
                        input logic bads, input logic [1:0] div, input bit glitch);
        int  n;
        logic pb;
        n = 16 * (int'(div) + 1);
        drive_bit(1'b0, n, 1'b0);
        for (int b = 0; b < 8; b++) drive_bit(ch[b], n, glitch);
        if (par <= 3'd3) begin
            case (par)
                3'd0:    pb = ^ch;
                3'd1:    pb = ~^ch;
                3'd2:    pb = 1'b0;
                default: pb = 1'b1;
            endcase
            drive_bit(pb ^ badp, n, 1'b0);
        end
        if (bads) begin
            drive_bit(1'b0, 12 * (int'(div) + 1), 1'b0);
            drive_bit(1'b1, 4 * (int'(div) + 1), 1'b0);
        end else begin
            drive_bit(1'b1, n, 1'b0);
        end
        drive_bit(1'b1, 8, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, m0;
        int lat;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(3'd0, d); check("R9 reset enable", d, 32'h0);
        rd(3'd1, d); check("R5 reset mode", d, 32'h0);
        rd(3'd2, d); check("R4 reset hold", d, 32'h0);
        check("R7 reset wake", {31'd0, wake}, 32'd0);

        wr(3'd0, 32'h10);
        rd(3'd0, d); check("R9 enable", d, 32'h10);

        // table of frames: R1 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            wr(3'd3, {30'd0, t.div});
            wr(3'd1, (32'(t.filt) << 4) | (32'(t.par) << 9));
            wr(3'd4, {8'd0, t.hi, 8'd0, t.lo});
            send(t.ch, t.par, t.badp, t.bads, t.div, 1'b0);
            check("R7 wake port", {31'd0, wake}, {31'd0, t.ewake});
            rd(3'd2, d);
            check("R1 R4 R5 R6 R7 frame", d, {21'd0, 1'b1, t.eerr, t.ewake, t.ch});
            check("R8 cleared after read", {31'd0, wake}, 32'd0);
        end

        // R2: short low pulse is discarded
        wr(3'd3, 32'd0);
        wr(3'd1, 32'd0);
        drive_bit(1'b0, 5, 1'b0);
        drive_bit(1'b1, 60, 1'b0);
        rd(3'd2, d); check("R2 glitch no frame", {21'd0, d[10:0]} >> 8, 32'd0);

        // R3: majority filter hides single-tick lows
        wr(3'd1, 32'h10 | (32'd4 << 9));
        wr(3'd4, 32'h00FF0000);
        send(8'hFF, 3'd4, 1'b0, 1'b0, 2'd0, 1'b1);
        rd(3'd2, d); check("R3 filtered frame", d, 32'h5FF);

        // R8: completion and clearing read on the same edge
        wr(3'd1, 32'd0);
        fork
            send(8'h3C, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0);
            begin
                lat = 0;
                while (!wake && lat < 400) begin @(negedge clk); lat++; end
            end
        join
        check("R8 reference latency found", {31'd0, lat < 400}, 32'd1);
        rd(3'd2, d);
        fork
            send(8'h3C, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0);
            begin
                repeat (lat - 1) @(negedge clk);
                reg_rd = 1'b1; reg_addr = 3'd2;
                @(negedge clk);
                reg_rd = 1'b0;
                check("R8 set wins over clear", {31'd0, wake}, 32'd1);
            end
        join
        rd(3'd2, d); check("R8 flags survive collision", d, 32'h53C);
        check("R8 second read clears", {31'd0, wake}, 32'd0);

        // R9: enable and disable together -> disabled; line ignored
        wr(3'd0, 32'h30);
        rd(3'd0, d); check("R9 disable wins", d, 32'h0);
        send(8'h41, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0);
        rd(3'd2, d); check("R9 disabled ignores line", {21'd0, d[10:8]}, 32'd0);

        // R9: reset command aborts frame and clears flags
        wr(3'd0, 32'h10);
        send(8'h42, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R7 wake before reset cmd", {31'd0, wake}, 32'd1);
        fork
            send(8'hFF, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0);
            begin
                repeat (80) @(negedge clk);
                wr(3'd0, 32'h04);
            end
        join
        check("R9 reset cmd clears wake", {31'd0, wake}, 32'd0);
        rd(3'd2, d); check("R9 reset cmd aborts frame", {29'd0, d[10:8]}, 32'd0);

        // R10: write protection
        wr(3'd5, {24'h123456, 8'h01});
        rd(3'd5, d); check("R10 wrong key discarded", d, 32'd0);
        wr(3'd5, {KEY, 8'h01});
        rd(3'd5, d); check("R10 key accepted, key reads 0", d, 32'd1);
        rd(3'd1, m0);
        wr(3'd1, 32'h0E10);
        rd(3'd1, d); check("R10 mode locked", d, m0);
        wr(3'd4, 32'h00330011);
        rd(3'd4, d); check("R10 compare locked", d, 32'h00FF0000);
        wr(3'd3, 32'd2);
        rd(3'd3, d); check("R10 divisor locked", d, 32'd0);
        wr(3'd5, {KEY, 8'h00});
        wr(3'd3, 32'd1);
        rd(3'd3, d); check("R10 R1 divisor after unlock", d, 32'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule